// File: doc/BRIEF.md
# Strap Mode Capture and External Interrupt Lines

This block serves pins that have two jobs. While reset is held, the pins are level straps. On every clock edge during reset, their states are copied into a small operating-mode register. The value from the last edge before release stays in the register. After reset the strap value is no longer sampled. Software can still overwrite the register through a one-cycle write strobe.

After reset, the two low-order strap pins become active-low external interrupt lines. Each line passes through its own synchronizer chain. A per-line select picks the trigger type:

- **Level:** the pending output follows the synchronized line.
- **Falling edge:** a high-to-low transition sets a sticky pending flag. The flag holds until an acknowledge pulse clears it.

Line 0 also drives a wake request for a stopped core. The wake request is formed without any clock, straight from the raw pin, while the stop indication is high.

Top module: `strap_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads `op_mode` with the pin levels: bit 0 from `irq_pin_n[0]`, bit 1 from `irq_pin_n[1]`, bit 2 from `mode_c_pin`. The value captured before release stays in `op_mode` afterwards.
- R2: After reset, `op_mode` changes only on a write. Pin activity leaves it unchanged.
- R3: With `mode_wr_en` high at a rising edge, `op_mode` shows `mode_wr_data` from that edge on.
- R4: With `edge_sel[i]`=0 (level), `irq_pend[i]` is the inverse of `irq_pin_n[i]` as it stood two rising edges earlier.
- R5: With `edge_sel[i]`=1 (falling edge), a high-to-low pin transition sets `irq_pend[i]` at the third rising edge after the pin falls. The flag stays set after the pin returns high, until it is acknowledged.
- R6: In falling-edge mode, `irq_ack[i]` high at a rising edge clears `irq_pend[i]`. If a new falling edge is detected at that same edge, the flag stays set.
- R7: In level mode, `irq_ack[i]` has no effect on `irq_pend[i]`.
- R8: In falling-edge mode, a rising transition or a line held low does not set `irq_pend[i]`.
- R9: While `rst_n` is low, `irq_pend` is 0. A line held low across reset release does not set falling-edge pending, but it shows as pending at once in level mode.
- R10: `wake_req` is high exactly when `stop_state` is 1, `rst_n` is 1 and `irq_pin_n[0]` is 0, with no clock edge needed. Line 1 never wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; strap capture window |
| irq_pin_n | input | NUM_IRQ | Raw strap/interrupt pins, active-low as interrupts |
| mode_c_pin | input | 1 | Third strap pin, mode bit only |
| edge_sel | input | NUM_IRQ | Per line trigger: 0 level, 1 falling edge |
| irq_ack | input | NUM_IRQ | Per line clear of the sticky edge flag |
| mode_wr_en | input | 1 | Software write strobe for the mode register |
| mode_wr_data | input | NUM_IRQ+1 | Value written to the mode register |
| stop_state | input | 1 | Core is in the clock-off stop state |
| op_mode | output | NUM_IRQ+1 | Operating-mode register |
| irq_pend | output | NUM_IRQ | Per line pending flag |
| wake_req | output | 1 | Unclocked wake request from line 0 |

## Verification
The bench targets the reset boundary.

- A synchronizer forced high in reset would report a false falling edge when a low-held line is released. A capture on the wrong edge would store the wrong strap bits.

It checks the exact cycle in which pending appears in both modes.

- An extra or missing register stage shifts the flag by one cycle and is seen at once.

It pulses acknowledge in the same cycle as a newly detected edge.

- An acknowledge-wins priority loses that interrupt.

It drives acknowledge on a level line, and line 1 while stopped.

- Acknowledge must not mask a level line, and line 1 must not raise the wake request.

// File: rtl/strap_irq_pkg.sv
package strap_irq_pkg;
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_e;

    // interrupt line that doubles as the stop-state wake source
    localparam int WAKE_LINE = 0;
endpackage

// File: rtl/strap_irq_chan.sv
module strap_irq_chan
    import strap_irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_sel,
    input  logic ack,
    output logic pend
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
        logic              sticky;
    } chan_t;

    chan_t st_d, st_q;
    logic  cur_s;
    logic  fell_s;
    logic  fall_mode;

    always_comb begin
        fall_mode = (trig_e'(edge_sel) == TRIG_FALL);
        cur_s     = st_q.sync[STAGES-1];
        fell_s    = st_q.prev & ~cur_s;
        st_d      = st_q;
        // chain keeps tracking the pin during reset so release sees no fake edge
        st_d.sync = {st_q.sync[STAGES-2:0], pin_n};
        st_d.prev = cur_s;
        if (!rst_n || !fall_mode) begin
            st_d.sticky = 1'b0;
        end else begin
            st_d.sticky = fell_s | (st_q.sticky & ~ack);
        end
        pend = rst_n & (fall_mode ? st_q.sticky : ~cur_s);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_mode && pend && !ack) |=> (pend || !fall_mode));

    // R8
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_mode && $past(fall_mode) && $rose(pend)) |-> !$past(cur_s));

    if (STAGES == 2) begin : g_lat
        // R4
        level_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!fall_mode && $past(rst_n, 2)) |-> (pend == !$past(pin_n, 2)));
    end
endmodule

// File: rtl/strap_mode_latch.sv
module strap_mode_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mode
);
    typedef struct packed {
        logic [W-1:0] mode;
    } latch_t;

    latch_t lt_d, lt_q;

    always_comb begin
        lt_d = lt_q;
        if (!rst_n) begin
            lt_d.mode = pins;
        end else if (wr_en) begin
            lt_d.mode = wr_data;
        end
        mode = lt_q.mode;
    end

    always_ff @(posedge clk) begin
        lt_q <= lt_d;
    end

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(mode));

    // R3
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode == $past(wr_data)));
endmodule

// File: rtl/strap_irq_ctrl.sv
module strap_irq_ctrl
    import strap_irq_pkg::*;
#(
    parameter int NUM_IRQ     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_pin_n,
    input  logic               mode_c_pin,
    input  logic [NUM_IRQ-1:0] edge_sel,
    input  logic [NUM_IRQ-1:0] irq_ack,
    input  logic               mode_wr_en,
    input  logic [NUM_IRQ:0]   mode_wr_data,
    input  logic               stop_state,
    output logic [NUM_IRQ:0]   op_mode,
    output logic [NUM_IRQ-1:0] irq_pend,
    output logic               wake_req
);
    localparam int MODE_W = NUM_IRQ + 1;

    logic [MODE_W-1:0] strap_s;

    assign strap_s = {mode_c_pin, irq_pin_n};

    strap_mode_latch #(.W(MODE_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (strap_s),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode    (op_mode)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        strap_irq_chan #(.STAGES(SYNC_STAGES)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (irq_pin_n[i]),
            .edge_sel (edge_sel[i]),
            .ack      (irq_ack[i]),
            .pend     (irq_pend[i])
        );
    end

    // no clock runs in stop state, so the request comes straight from the pin
    assign wake_req = stop_state & rst_n & ~irq_pin_n[WAKE_LINE];
endmodule

// File: tb/strap_irq_ctrl_bench.sv
module strap_irq_ctrl_bench;
    localparam int NUM_IRQ = 2;
    localparam int WATCHDOG_NS = 200000 * 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [NUM_IRQ-1:0] irq_pin_n;
    logic mode_c_pin;
    logic [NUM_IRQ-1:0] edge_sel;
    logic [NUM_IRQ-1:0] irq_ack;
    logic mode_wr_en;
    logic [NUM_IRQ:0] mode_wr_data;
    logic stop_state;
    logic [NUM_IRQ:0] op_mode;
    logic [NUM_IRQ-1:0] irq_pend;
    logic wake_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    strap_irq_ctrl #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(2)) u_strap_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .mode_c_pin(mode_c_pin),
        .edge_sel(edge_sel), .irq_ack(irq_ack), .mode_wr_en(mode_wr_en),
        .mode_wr_data(mode_wr_data), .stop_state(stop_state),
        .op_mode(op_mode), .irq_pend(irq_pend), .wake_req(wake_req)
    );

    // {a_n, b_n, ack_a, ack_b, exp_pend_a, exp_pend_b}; line A edge, line B level
    localparam logic [5:0] VEC [0:14] = '{
        6'b110000, 6'b000000, 6'b000001, 6'b100011, 6'b110111,
        6'b111000, 6'b010000, 6'b110000, 6'b110010, 6'b011000,
        6'b111000, 6'b111010, 6'b110010, 6'b110010, 6'b111000
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        rst_n = 1'b0; irq_pin_n = 2'b10; mode_c_pin = 1'b1; edge_sel = 2'b01;
        irq_ack = '0; mode_wr_en = 1'b0; mode_wr_data = '0; stop_state = 1'b0;

        // reset capture
        repeat (4) @(negedge clk);
        chk("R1 capture in reset", {1'b0, op_mode}, 4'b0110);
        chk("R9 pend zero in reset", {2'b0, irq_pend}, 4'b0000);
        stop_state = 1'b1; #1;
        chk("R10 no wake in reset", {3'b0, wake_req}, 4'b0000);
        stop_state = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 held after release", {1'b0, op_mode}, 4'b0110);
        chk("R9 no edge from low-held line", {3'b0, irq_pend[0]}, 4'b0000);
        edge_sel = 2'b00; #1;
        chk("R9 level shows held line", {2'b0, irq_pend}, 4'b0001);
        edge_sel = 2'b01;

        // pins wiggle after reset
        irq_pin_n = 2'b01; mode_c_pin = 1'b0;
        repeat (2) @(negedge clk);
        irq_pin_n = 2'b11;
        repeat (4) @(negedge clk);
        chk("R2 mode ignores pins", {1'b0, op_mode}, 4'b0110);

        // vector table (R4 R5 R6 R7 R8)
        for (int k = 0; k < 15; k++) begin
            irq_pin_n = {VEC[k][4], VEC[k][5]};
            irq_ack   = {VEC[k][2], VEC[k][3]};
            @(negedge clk);
            chk($sformatf("R5 R6 R8 line A row %0d", k), {3'b0, irq_pend[0]}, {3'b0, VEC[k][1]});
            chk($sformatf("R4 R7 line B row %0d", k), {3'b0, irq_pend[1]}, {3'b0, VEC[k][0]});
        end
        irq_ack = '0;

        // software write
        mode_wr_en = 1'b1; mode_wr_data = 3'b011;
        @(negedge clk);
        mode_wr_en = 1'b0;
        chk("R3 write visible", {1'b0, op_mode}, 4'b0011);
        irq_pin_n = 2'b00; mode_c_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 written mode kept", {1'b0, op_mode}, 4'b0011);
        irq_pin_n = 2'b11;
        repeat (3) @(negedge clk);

        // wake request
        stop_state = 1'b1; irq_pin_n[0] = 1'b0; #1;
        chk("R10 wake on line 0 low", {3'b0, wake_req}, 4'b0001);
        irq_pin_n[0] = 1'b1; #1;
        chk("R10 wake drops", {3'b0, wake_req}, 4'b0000);
        irq_pin_n[1] = 1'b0; #1;
        chk("R10 line 1 never wakes", {3'b0, wake_req}, 4'b0000);
        irq_pin_n[1] = 1'b1; stop_state = 1'b0; irq_pin_n[0] = 1'b0; #1;
        chk("R10 no wake outside stop", {3'b0, wake_req}, 4'b0000);
        irq_pin_n[0] = 1'b1;

        // second capture pattern
        @(negedge clk);
        rst_n = 1'b0; irq_pin_n = 2'b01; mode_c_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 second capture", {1'b0, op_mode}, 4'b0001);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1 run hung actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule